// File: doc/BRIEF.md
# Expanding Opcode Instruction Decoder

This block decodes a 36-bit fixed-length instruction word whose opcode length depends on how many operands the instruction carries. The three leading bits form a short opcode for the class with the most operands: two 15-bit addresses and a 3-bit register. One short pattern, all ones, is held back as an escape. Behind the escape, a 15-bit sub-opcode selects either the class with one address and one register, or (when it is all ones) the class with no operands, whose 18 trailing bits carry the final opcode.

Each accepted word is held in a register for one cycle and then decoded. The decoder reports the class, the extracted fields and a single flat index numbering every legal instruction. Words that land in unassigned code space raise an illegal flag. A downstream sequencer uses the index to select a microprogram and the fields to form its operands. A word never matches more than one class, because no escape prefix equals a short opcode that is in use.

Top module: `ed_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid is 0 and every other output is 0.
- R2: out_valid equals the in_valid sampled at the previous rising clock edge. The outputs describe the word sampled at that same edge.
- R3: If bits [35:33] hold a value from 0 to 6, the class is two-address (out_class=1). out_addr_a=[32:18], out_addr_b=[17:3], out_reg=[2:0], and out_index equals bits [35:33].
- R4: If bits [35:33]=7 and bits [32:18] hold a value from 0 to 499, the class is one-address (out_class=2). out_addr_a=[17:3], out_reg=[2:0], out_addr_b=0, and out_index=7+[32:18].
- R5: If bits [35:33]=7, bits [32:18]=32767 and bits [17:0] hold a value from 0 to 49, the class is no-operand (out_class=3). out_index=507+[17:0], and all field outputs are 0.
- R6: Any other word is illegal. Bits [35:33]=7 with [32:18] from 500 to 32766 is illegal, and so is [32:18]=32767 with [17:0] of 50 or more. For an illegal word, out_illegal=1, out_class=0, and out_index and all fields are 0.
- R7: When out_valid is 1, out_illegal is 1 exactly when out_class is 0.
- R8: out_index lies in 0..6 for class 1, in 7..506 for class 2 and in 507..556 for class 3.
- R9: A word presented with in_valid=0 has no effect. In the next cycle out_valid is 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_word carries an instruction |
| in_word | input | 36 | Instruction word |
| out_valid | output | 1 | Decoded result is present |
| out_illegal | output | 1 | Word is in unassigned code space |
| out_class | output | 2 | 0 illegal/none, 1 two-address, 2 one-address, 3 no-operand |
| out_index | output | 10 | Flat instruction index 0..556 |
| out_addr_a | output | 15 | First address field |
| out_addr_b | output | 15 | Second address field |
| out_reg | output | 3 | Register field |

## Verification
The bench targets the edges of each sub-range. It drives short opcodes 0 and 6, sub-opcodes 499 and 500, sub-opcode 32766 next to the escape value 32767, and no-operand codes 49 and 50. An off-by-one compare would mark sub-opcode 500 or code 50 legal, or would reject 499 or 49. A wrong escape test would let prefix 7 fall into the two-address class. It also sends all-ones payloads to show that the escape pattern is not a wildcard. Swapped field slices show up as wrong address values when the payloads are asymmetric. An idle cycle carrying a nonzero word exposes a decoder that ignores in_valid. A reset applied mid-stream exposes a stale output register.

// File: rtl/ed_pkg.sv
package ed_pkg;

    localparam int PRE_W   = 3;
    localparam int ADDR_W  = 15;
    localparam int REG_W   = 3;
    localparam int WORD_W  = PRE_W + 2 * ADDR_W + REG_W;
    localparam int LOW_W   = ADDR_W + REG_W;

    localparam int N_TWO   = 7;
    localparam int N_ONE   = 500;
    localparam int N_NONE  = 50;
    localparam int N_TOTAL = N_TWO + N_ONE + N_NONE;
    localparam int IDX_W   = $clog2(N_TOTAL);

    localparam logic [PRE_W-1:0]  ESC_PRE  = '1;
    localparam logic [ADDR_W-1:0] ESC_SUB  = '1;
    localparam logic [PRE_W-1:0]  TWO_LIM  = PRE_W'(N_TWO);
    localparam logic [ADDR_W-1:0] ONE_LIM  = ADDR_W'(N_ONE);
    localparam logic [LOW_W-1:0]  NONE_LIM = LOW_W'(N_NONE);
    localparam logic [IDX_W-1:0]  BASE_ONE  = IDX_W'(N_TWO);
    localparam logic [IDX_W-1:0]  BASE_NONE = IDX_W'(N_TWO + N_ONE);

    typedef enum logic [1:0] {
        CLS_BAD  = 2'd0,
        CLS_TWO  = 2'd1,
        CLS_ONE  = 2'd2,
        CLS_NONE = 2'd3
    } cls_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [ADDR_W-1:0] sub;
        logic [LOW_W-1:0]  low;
    } word_t;

    typedef struct packed {
        cls_e              cls;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [REG_W-1:0]  rsel;
    } dec_t;

    function automatic cls_e classify(input word_t w);
        cls_e c;
        c = CLS_BAD;
        if (w.pre != ESC_PRE) begin
            if (w.pre < TWO_LIM) c = CLS_TWO;
        end else if (w.sub < ONE_LIM) begin
            c = CLS_ONE;
        end else if (w.sub == ESC_SUB) begin
            if (w.low < NONE_LIM) c = CLS_NONE;
        end
        return c;
    endfunction

endpackage

// File: rtl/ed_in_reg.sv
module ed_in_reg
    import ed_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         d_valid,
    input  logic [W-1:0] d_word,
    output logic         q_valid,
    output logic [W-1:0] q_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_word  <= '0;
        end else begin
            q_valid <= d_valid;
            q_word  <= d_valid ? d_word : '0;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (q_valid == $past(d_valid)));

    p_idle_word_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !d_valid) |-> (q_word == '0));

endmodule

// File: rtl/ed_class_decode.sv
module ed_class_decode
    import ed_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output cls_e              cls
);

    word_t w;

    always_comb begin
        w   = word_t'(word);
        cls = valid ? classify(w) : CLS_BAD;
    end

endmodule

// File: rtl/ed_field_extract.sv
module ed_field_extract
    import ed_pkg::*;
(
    input  cls_e              cls,
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);

    logic [PRE_W-1:0]  f_pre;
    logic [ADDR_W-1:0] f_hi;
    logic [ADDR_W-1:0] f_mid;
    logic [REG_W-1:0]  f_reg;
    logic [LOW_W-1:0]  f_low;

    always_comb begin
        {f_pre, f_hi, f_mid, f_reg} = word;
        f_low = {f_mid, f_reg};
        dec   = '0;
        dec.cls = cls;
        unique case (cls)
            CLS_TWO: begin
                dec.idx    = IDX_W'(f_pre);
                dec.addr_a = f_hi;
                dec.addr_b = f_mid;
                dec.rsel   = f_reg;
            end
            CLS_ONE: begin
                dec.idx    = BASE_ONE + IDX_W'(f_hi);
                dec.addr_a = f_mid;
                dec.rsel   = f_reg;
            end
            CLS_NONE: begin
                dec.idx    = BASE_NONE + IDX_W'(f_low);
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/ed_decoder.sv
module ed_decoder
    import ed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [1:0]        out_class,
    output logic [IDX_W-1:0]  out_index,
    output logic [ADDR_W-1:0] out_addr_a,
    output logic [ADDR_W-1:0] out_addr_b,
    output logic [REG_W-1:0]  out_reg
);

    logic              r_valid;
    logic [WORD_W-1:0] r_word;
    cls_e              cls;
    dec_t              dec;

    ed_in_reg #(.W(WORD_W)) u_in_reg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_word  (in_word),
        .q_valid (r_valid),
        .q_word  (r_word)
    );

    ed_class_decode u_class (
        .valid (r_valid),
        .word  (r_word),
        .cls   (cls)
    );

    ed_field_extract u_fields (
        .cls  (cls),
        .word (r_word),
        .dec  (dec)
    );

    always_comb begin
        out_valid   = r_valid;
        out_illegal = r_valid && (dec.cls == CLS_BAD);
        out_class   = dec.cls;
        out_index   = dec.idx;
        out_addr_a  = dec.addr_a;
        out_addr_b  = dec.addr_b;
        out_reg     = dec.rsel;
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_index == '0 && out_class == 2'd0));

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_illegal == (out_class == 2'd0)));

    p_range_two_r8: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'd1) |-> (out_index < BASE_ONE));

    p_range_one_r8: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'd2) |-> (out_index >= BASE_ONE && out_index < BASE_NONE));

    p_range_none_r8: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'd3) |-> (out_index >= BASE_NONE && out_index < IDX_W'(N_TOTAL)));

    p_bad_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_index == '0 && out_addr_a == '0 && out_addr_b == '0 && out_reg == '0));

    p_none_fields_r5: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'd3) |-> (out_addr_a == '0 && out_addr_b == '0 && out_reg == '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_illegal && out_class == 2'd0 && out_index == '0));

endmodule

// File: tb/ed_decoder_bench.sv
module ed_decoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [35:0] in_word;
    logic        out_valid, out_illegal;
    logic [1:0]  out_class;
    logic [9:0]  out_index;
    logic [14:0] out_addr_a, out_addr_b;
    logic [2:0]  out_reg;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ed_decoder u_ed_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_class(out_class),
        .out_index(out_index), .out_addr_a(out_addr_a), .out_addr_b(out_addr_b),
        .out_reg(out_reg)
    );

    // expected: {valid, illegal, class, index, addr_a, addr_b, reg}
    localparam int NV = 13;
    localparam logic [35:0] VW [NV] = '{
        {3'd0, 15'd0,      15'd0,      3'd0},
        {3'd6, 15'h7FFF,   15'd1,      3'd7},
        {3'd3, 15'h1234,   15'h5678,   3'd5},
        {3'd7, 15'd0,      15'h0ABC,   3'd2},
        {3'd7, 15'd499,    15'h7FFF,   3'd7},
        {3'd7, 15'd250,    15'd3,      3'd4},
        {3'd7, 15'd500,    15'd5,      3'd1},
        {3'd7, 15'd32766,  15'h7FFF,   3'd7},
        {3'd7, 15'h7FFF,   18'd0},
        {3'd7, 15'h7FFF,   18'd49},
        {3'd7, 15'h7FFF,   18'd50},
        {3'd7, 15'h7FFF,   18'h3FFFF},
        {3'd7, 15'h7FFF,   18'd17}
    };
    localparam logic [46:0] VE [NV] = '{
        {1'b1, 1'b0, 2'd1, 10'd0,   15'd0,      15'd0,    3'd0},
        {1'b1, 1'b0, 2'd1, 10'd6,   15'h7FFF,   15'd1,    3'd7},
        {1'b1, 1'b0, 2'd1, 10'd3,   15'h1234,   15'h5678, 3'd5},
        {1'b1, 1'b0, 2'd2, 10'd7,   15'h0ABC,   15'd0,    3'd2},
        {1'b1, 1'b0, 2'd2, 10'd506, 15'h7FFF,   15'd0,    3'd7},
        {1'b1, 1'b0, 2'd2, 10'd257, 15'd3,      15'd0,    3'd4},
        {1'b1, 1'b1, 2'd0, 10'd0,   15'd0,      15'd0,    3'd0},
        {1'b1, 1'b1, 2'd0, 10'd0,   15'd0,      15'd0,    3'd0},
        {1'b1, 1'b0, 2'd3, 10'd507, 15'd0,      15'd0,    3'd0},
        {1'b1, 1'b0, 2'd3, 10'd556, 15'd0,      15'd0,    3'd0},
        {1'b1, 1'b1, 2'd0, 10'd0,   15'd0,      15'd0,    3'd0},
        {1'b1, 1'b1, 2'd0, 10'd0,   15'd0,      15'd0,    3'd0},
        {1'b1, 1'b0, 2'd3, 10'd524, 15'd0,      15'd0,    3'd0}
    };
    localparam string VT [NV] = '{
        "R3", "R3", "R3", "R4", "R4", "R4", "R6", "R6", "R5", "R5", "R6", "R6", "R5"
    };
    localparam logic [46:0] ZERO_OUT = '0;

    function automatic logic [46:0] snap();
        return {out_valid, out_illegal, out_class, out_index, out_addr_a, out_addr_b, out_reg};
    endfunction

    task automatic check(input string tag, input logic [46:0] exp);
        logic [46:0] got;
        got = snap();
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [35:0] w);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
    endtask

    bit done = 1'b0;

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b1;
        in_word = {3'd1, 15'h7FFF, 15'h7FFF, 3'd7};
        repeat (3) @(negedge clk);
        check("R1 during reset", ZERO_OUT);
        rst = 1'b0;
        in_valid = 1'b0;
        in_word = '0;
        @(negedge clk);
        check("R1 after reset", ZERO_OUT);

        // vector table, one word per cycle, result one edge later (R2)
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VW[i]);
            @(negedge clk);
            check(VT[i], VE[i]);
        end

        // R2: back-to-back stream, each result one cycle behind its word
        drive(1'b1, VW[1]);
        drive(1'b1, VW[4]);
        check("R2 stream first", VE[1]);
        drive(1'b1, VW[9]);
        check("R2 stream second", VE[4]);
        drive(1'b0, VW[2]);
        check("R2 stream third", VE[9]);
        // R9: nonzero word with in_valid low leaves no trace
        @(negedge clk);
        check("R9 idle word ignored", ZERO_OUT);

        // R7: illegal flag only with class 0 and valid
        drive(1'b1, {3'd7, 15'd12345, 18'd0});
        @(negedge clk);
        check("R7 illegal mid sub-range", {1'b1, 1'b1, 2'd0, 10'd0, 15'd0, 15'd0, 3'd0});

        // R1: reset mid-stream clears a pending result
        drive(1'b1, VW[3]);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-stream", ZERO_OUT);
        rst = 1'b0;
        drive(1'b1, VW[5]);
        @(negedge clk);
        check("R8 one-address index after reset", VE[5]);
        drive(1'b0, '0);
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule